// File: doc/BRIEF.md
# Microinstruction Spacing Rule Monitor

This block watches a decoded microinstruction issue stream and reports sequences that break minimum-spacing rules on slow side-effect operations. Each cycle it receives five decoded flags: load-timer, add-to-timer, panel-clear, panel-increment and conditional-branch-present. For each anchor event it keeps a small saturating counter of cycles elapsed since that event. When an operation arrives too soon after its anchor, or a timer operation shares its slot with a conditional branch, it raises a one-cycle violation pulse with a 2-bit reason code.

The monitor never stalls or blocks issue; it only observes. Thresholds are elaboration-time parameters counted in machine cycles. An instruction normally spans two machine cycles, so the timer default of 14 cycles corresponds to roughly seven instructions. The timer and the panel themselves are not modelled.

Top module: `uinst_spacing_monitor`

## Requirements
- R1: After synchronous reset, `viol_pulse` is 0, and every counter starts saturated, so the first timer, clear or increment operation never violates a gap rule.
- R2: A timer operation (load or add, in any mix) issued fewer than `TMR_GAP` (default 14) cycles after the previous timer operation is a violation with reason code 0.
- R3: A timer operation issued exactly `TMR_GAP` or more cycles after the previous one does not violate the timer gap rule.
- R4: A timer operation issued in the same cycle as a conditional branch is a violation with reason code 1.
- R5: A panel increment issued fewer than `CLR_GAP` (default 12) cycles after the last panel clear is a violation with reason code 2; at `CLR_GAP` cycles or more it is legal.
- R6: A panel increment issued fewer than `INC_GAP` (default 6) cycles after the previous panel increment is a violation with reason code 3; at `INC_GAP` cycles or more it is legal.
- R7: When several rules fail in the same cycle, the lowest reason code is reported (0 before 1 before 2 before 3).
- R8: `viol_pulse` and `viol_code` are registered: they reflect the instruction presented in the previous cycle and the pulse lasts one cycle per offending instruction.
- R9: Every operation restarts the counter of its own kind, even when it is itself a violation; gaps are measured only against operations in earlier cycles; a branch or a panel clear alone never produces a violation.
- R10: Counters saturate at their threshold, so an arbitrarily long idle period never wraps them and the next operation is legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_tmr_load | input | 1 | Current instruction loads the timer |
| op_tmr_add | input | 1 | Current instruction adds to the timer |
| op_pnl_clear | input | 1 | Current instruction clears the panel |
| op_pnl_inc | input | 1 | Current instruction increments the panel |
| op_cond_br | input | 1 | Current instruction carries a conditional branch |
| viol_pulse | output | 1 | One-cycle violation indication |
| viol_code | output | 2 | Reason: 0 timer gap, 1 timer with branch, 2 clear-to-increment gap, 3 increment-to-increment gap |

## Verification
The timer-gap rule and the timer-with-branch rule can fail on the very same instruction, and likewise the two panel rules can both fail on one increment; a third collision pairs a timer-gap failure with a panel failure. The bench provokes each by placing a branch-carrying timer operation inside the 14-cycle window, and an increment that is both within 12 cycles of a clear and within 6 of the previous increment, then judges that the pulse carries the lowest failing code. A cycle-indexed reference model of last-event times predicts every cycle's pulse and code independently of the counters.

// File: rtl/spacing_pkg.sv
package spacing_pkg;

  localparam int NUM_RULES = 4;

  typedef enum logic [1:0] {
    RC_TMR_GAP = 2'd0,
    RC_TMR_BR  = 2'd1,
    RC_CLR_INC = 2'd2,
    RC_INC_INC = 2'd3
  } reason_t;

endpackage

// File: rtl/gap_counter.sv
module gap_counter #(
  parameter int GAP = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic anchor,
  output logic too_soon
);
  localparam int W = (GAP > 2) ? $clog2(GAP) : 1;
  localparam logic [W-1:0] LIM = W'(GAP - 1);

  logic [W-1:0] cnt;

  // cnt holds (cycles since anchor) - 1, saturating at GAP-1
  assign too_soon = (cnt < LIM);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= LIM;
    else if (anchor)
      cnt <= '0;
    else if (cnt < LIM)
      cnt <= cnt + W'(1);
  end

  assert_cnt_bounded_R10: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);

  assert_sat_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt == LIM && !anchor) |=> (cnt == LIM));

endmodule

// File: rtl/rule_arbiter.sv
module rule_arbiter
  import spacing_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_RULES-1:0] fail,
  output logic                 pulse,
  output reason_t              code
);
  reason_t pick;

  always_comb begin
    pick = RC_TMR_GAP;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (fail[i]) pick = reason_t'(i[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      code  <= RC_TMR_GAP;
    end else begin
      pulse <= |fail;
      code  <= pick;
    end
  end

  assert_pulse_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(|fail));

  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (pulse && code != RC_TMR_GAP) |-> !$past(fail[0]));

endmodule

// File: rtl/uinst_spacing_monitor.sv
module uinst_spacing_monitor
  import spacing_pkg::*;
#(
  parameter int TMR_GAP = 14,
  parameter int CLR_GAP = 12,
  parameter int INC_GAP = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       op_tmr_load,
  input  logic       op_tmr_add,
  input  logic       op_pnl_clear,
  input  logic       op_pnl_inc,
  input  logic       op_cond_br,
  output logic       viol_pulse,
  output logic [1:0] viol_code
);
  localparam int NUM_CNT = 3;
  localparam int IDX_TMR = 0;
  localparam int IDX_CLR = 1;
  localparam int IDX_INC = 2;

  function automatic int gap_of(input int idx);
    case (idx)
      IDX_TMR: return TMR_GAP;
      IDX_CLR: return CLR_GAP;
      default: return INC_GAP;
    endcase
  endfunction

  logic                 tmr_any;
  logic [NUM_CNT-1:0]   anchors;
  logic [NUM_CNT-1:0]   soon;
  logic [NUM_RULES-1:0] fail;
  reason_t              code_r;

  assign tmr_any = op_tmr_load | op_tmr_add;
  assign anchors = {op_pnl_inc, op_pnl_clear, tmr_any};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    gap_counter #(.GAP(gap_of(g))) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .anchor   (anchors[g]),
      .too_soon (soon[g])
    );
  end

  always_comb begin
    fail                 = '0;
    fail[int'(RC_TMR_GAP)] = tmr_any & soon[IDX_TMR];
    fail[int'(RC_TMR_BR)]  = tmr_any & op_cond_br;
    fail[int'(RC_CLR_INC)] = op_pnl_inc & soon[IDX_CLR];
    fail[int'(RC_INC_INC)] = op_pnl_inc & soon[IDX_INC];
  end

  rule_arbiter u_arb (
    .clk   (clk),
    .rst   (rst),
    .fail  (fail),
    .pulse (viol_pulse),
    .code  (code_r)
  );

  assign viol_code = code_r;

  assert_branch_code_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (viol_pulse && viol_code == 2'd1) |-> $past(op_cond_br && (op_tmr_load || op_tmr_add)));

  assert_timer_code_cause_R2: assert property (@(posedge clk) disable iff (rst)
    (viol_pulse && viol_code == 2'd0) |-> $past(op_tmr_load || op_tmr_add));

  assert_panel_code_cause_R5: assert property (@(posedge clk) disable iff (rst)
    (viol_pulse && viol_code[1]) |-> $past(op_pnl_inc));

  assert_no_false_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!(op_tmr_load || op_tmr_add || op_pnl_inc)) |-> !viol_pulse);

endmodule

// File: tb/tb_uinst_spacing_monitor.sv
module tb_uinst_spacing_monitor;
  localparam int TMR_GAP = 14;
  localparam int CLR_GAP = 12;
  localparam int INC_GAP = 6;

  typedef struct {
    logic  pulse;
    int    code;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tl = 0, ta = 0, pc = 0, pi = 0, br = 0;
  logic viol_pulse;
  logic [1:0] viol_code;

  int checks = 0, errors = 0;
  int cyc = 0;
  int last_t = -1000, last_c = -1000, last_i = -1000;
  bit done = 0;
  exp_t sb[$];

  always #10 clk = ~clk;

  uinst_spacing_monitor #(.TMR_GAP(TMR_GAP), .CLR_GAP(CLR_GAP), .INC_GAP(INC_GAP)) dut (
    .clk(clk), .rst(rst),
    .op_tmr_load(tl), .op_tmr_add(ta), .op_pnl_clear(pc), .op_pnl_inc(pi),
    .op_cond_br(br), .viol_pulse(viol_pulse), .viol_code(viol_code)
  );

  // driver: one instruction per cycle, expectation from the rules alone
  task automatic step(input bit l, input bit a, input bit c, input bit i,
                      input bit b, input string req);
    exp_t e;
    @(negedge clk);
    tl = l; ta = a; pc = c; pi = i; br = b;
    e.pulse = 1'b0; e.code = 0; e.req = req;
    if ((l || a) && (cyc - last_t) < TMR_GAP)      begin e.pulse = 1; e.code = 0; end
    else if ((l || a) && b)                        begin e.pulse = 1; e.code = 1; end
    else if (i && (cyc - last_c) < CLR_GAP)        begin e.pulse = 1; e.code = 2; end
    else if (i && (cyc - last_i) < INC_GAP)        begin e.pulse = 1; e.code = 3; end
    if (l || a) last_t = cyc;
    if (c)      last_c = cyc;
    if (i)      last_i = cyc;
    cyc++;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, "R10");
  endtask

  // monitor: pops the item driven before the preceding rising edge
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (viol_pulse !== e.pulse || (e.pulse && int'(viol_code) != e.code)) begin
        errors++;
        $display("FAIL %s: got pulse=%0b code=%0d, expected pulse=%0b code=%0d",
                 e.req, viol_pulse, viol_code, e.pulse, e.code);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (viol_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R1: got pulse=%0b, expected pulse=0 in reset", viol_pulse);
    end
    rst = 0;

    // R1: first operation of each kind after reset is legal
    step(1, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 0, "R1");
    idle(20);
    step(0, 0, 1, 0, 0, "R1");
    idle(20);

    // R2/R3: timer gap, mixed load and add, boundary 13 vs 14
    step(0, 1, 0, 0, 0, "R3");
    idle(12);
    step(1, 0, 0, 0, 0, "R2");       // 13 cycles after -> code 0
    idle(13);
    step(0, 1, 0, 0, 0, "R3");       // exactly 14 after the violating op (R9 restart)
    step(1, 0, 0, 0, 0, "R2");       // back-to-back
    idle(20);

    // R4: timer with branch, gap satisfied
    step(1, 0, 0, 0, 1, "R4");
    idle(20);
    step(0, 1, 0, 0, 1, "R4");
    step(0, 0, 0, 0, 1, "R9");       // branch alone is harmless
    idle(20);

    // R7: timer gap and branch in same slot -> code 0
    step(1, 0, 0, 0, 0, "R3");
    idle(4);
    step(0, 1, 0, 0, 1, "R7");
    idle(20);

    // R5: clear to increment, boundary 11 vs 12
    step(0, 0, 1, 0, 0, "R9");
    idle(10);
    step(0, 0, 0, 1, 0, "R5");       // 11 cycles -> code 2
    idle(20);
    step(0, 0, 1, 0, 0, "R9");
    idle(11);
    step(0, 0, 0, 1, 0, "R5");       // exactly 12 -> legal

    // R6: increment to increment, boundary 5 vs 6
    idle(4);
    step(0, 0, 0, 1, 0, "R6");       // 5 cycles -> code 3
    idle(5);
    step(0, 0, 0, 1, 0, "R6");       // exactly 6 -> legal
    step(0, 0, 0, 1, 0, "R6");       // back-to-back -> code 3

    // R7: both panel rules fail on one increment -> code 2
    step(0, 0, 1, 0, 0, "R9");
    step(0, 0, 0, 1, 0, "R7");
    // R9: clear and increment in one slot judged against earlier history
    idle(20);
    step(0, 0, 1, 1, 0, "R9");
    step(0, 0, 0, 1, 0, "R7");

    // R7: timer gap and panel gap in one slot -> code 0
    idle(20);
    step(1, 0, 1, 0, 0, "R9");
    idle(2);
    step(1, 0, 0, 1, 1, "R7");

    // R10: long idle then every kind again
    idle(300);
    step(1, 0, 0, 1, 0, "R10");
    step(0, 0, 1, 0, 0, "R10");

    // R8: single-cycle pulse; trailing idles confirm it drops
    idle(3);
    step(0, 0, 0, 0, 0, "R8");

    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R8: got %0d pending results, expected 0", sb.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule